// File: doc/BRIEF.md
# Phase-Mixer Steering Controller

This block is the digital half of a clock-recovery loop. A phase detector outside the block sends early and late strobes. The block counts them into an 8-bit phase counter that wraps around. It adds a calibration offset, and the offset is loaded once through a small write port. The sum is then turned into the settings for an analog phase mixer. The mixer receives the indices of two neighbouring reference phases and a thermometer-coded weight for blending between them.

The phase word has 256 codes, which cover one clock period evenly. The reference set has twelve sectors: six phases 30 degrees apart plus their inverses. An optional vote filter makes the loop wait for several agreeing strobes before the counter moves, which reduces dither. The offset is held constant after it is written, so the calibration result stays applied while the loop keeps tracking.

Top module: `pmc_top`

## Requirements
- R1: While `rst_i` is high at a clock edge, the phase counter and the offset are cleared, and after that edge the outputs read `sel_lo_o`=0, `sel_hi_o`=1, `weight_o`=0.
- R2: With `FILT_N`=1, a cycle with `up_i`=1 and `dn_i`=0 raises the counter by one modulo 256, so 255 wraps to 0.
- R3: With `FILT_N`=1, a cycle with `dn_i`=1 and `up_i`=0 lowers the counter by one modulo 256, so 0 wraps to 255.
- R4: A cycle with both strobes high, or both low, leaves the counter unchanged.
- R5: A cycle with `ofs_we_i`=1 stores `ofs_val_i` as the offset and does not change the counter. The decoded phase P is (counter + offset) modulo 256.
- R6: `sel_lo_o` equals floor(P*12/256), a value from 0 to 11.
- R7: `sel_hi_o` equals (`sel_lo_o`+1) modulo 12.
- R8: Let L = floor(((P*12) mod 256)/32), a value from 0 to 7. `weight_o` has bits [L-1:0] set and all other bits clear, with bit 0 as the first bit to fill.
- R9: The counter and the offset change on the edge that samples the strobe or write. The outputs reflect the new state one edge later.
- R10: With `FILT_N`>1, the counter moves only after `FILT_N` strobes in the same direction. A strobe in the opposite direction restarts the tally at one in its own direction. Idle cycles and both-high cycles keep the tally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| up_i | input | 1 | Late strobe from the phase detector (advance phase) |
| dn_i | input | 1 | Early strobe from the phase detector (retard phase) |
| ofs_we_i | input | 1 | Offset write enable |
| ofs_val_i | input | 8 | Offset value to store |
| sel_lo_o | output | 4 | Index of the lower reference phase of the pair |
| sel_hi_o | output | 4 | Index of the upper reference phase of the pair |
| weight_o | output | 7 | Thermometer interpolation weight |

## Verification
The wrap of the phase word is the hardest state to reach from the ports, because the counter has to be driven across 0/255 while the offset also moves the decoded phase. The stimulus table first walks the counter below zero using a nonzero offset. It then clears the offset, so P lands on 255 (sector 11, pair 11 and 0), and then steps up so P wraps to 0. Small steps near 0 do not change the outputs, so the offset is used to park P at the sector edges (21/22) and at points inside a sector where the weight changes. A second instance with a three-vote filter receives interleaved opposing, idle and both-high strobes, and the bench checks when the single step appears.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int PHASE_W = 8;
    localparam int NSECT   = 12;
    localparam int SECT_W  = $clog2(NSECT);
    localparam int LVL_W   = 3;
    localparam int THERM_W = (1 << LVL_W) - 1;
    localparam int PROD_W  = PHASE_W + SECT_W;

    typedef logic [PHASE_W-1:0] phase_t;
    typedef logic [SECT_W-1:0]  sect_t;

    typedef struct packed {
        phase_t cnt;
        phase_t ofs;
    } acc_st_t;

    typedef struct packed {
        sect_t              lo;
        sect_t              hi;
        logic [THERM_W-1:0] wt;
    } dec_st_t;
endpackage

// File: rtl/pmc_vote.sv
module pmc_vote #(
    parameter int FILT_N = 1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic up_i,
    input  logic dn_i,
    output logic step_up_o,
    output logic step_dn_o
);
    localparam int VW = (FILT_N < 2) ? 1 : $clog2(FILT_N + 1);
    localparam logic [VW-1:0] LIM = VW'(FILT_N);

    typedef struct packed {
        logic          dir_dn;
        logic [VW-1:0] tally;
    } vote_st_t;

    vote_st_t st_d, st_q;
    logic [VW-1:0] nxt_tally;

    always_comb begin
        st_d      = st_q;
        step_up_o = 1'b0;
        step_dn_o = 1'b0;
        nxt_tally = '0;
        if (up_i != dn_i) begin
            if ((st_q.dir_dn != dn_i) || (st_q.tally == '0))
                nxt_tally = VW'(1);
            else
                nxt_tally = st_q.tally + VW'(1);
            st_d.dir_dn = dn_i;
            if (nxt_tally == LIM) begin
                st_d.tally = '0;
                step_up_o  = up_i;
                step_dn_o  = dn_i;
            end else begin
                st_d.tally = nxt_tally;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end
endmodule

// File: rtl/pmc_acc.sv
module pmc_acc
    import pmc_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   step_up_i,
    input  logic   step_dn_i,
    input  logic   ofs_we_i,
    input  phase_t ofs_val_i,
    output phase_t cnt_o,
    output phase_t ofs_o,
    output phase_t phase_o
);
    acc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_up_i)      st_d.cnt = st_q.cnt + phase_t'(1);
        else if (step_dn_i) st_d.cnt = st_q.cnt - phase_t'(1);
        if (ofs_we_i)       st_d.ofs = ofs_val_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign ofs_o   = st_q.ofs;
    assign phase_o = st_q.cnt + st_q.ofs;
endmodule

// File: rtl/pmc_dec.sv
module pmc_dec
    import pmc_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  phase_t             phase_i,
    output sect_t              lo_o,
    output sect_t              hi_o,
    output logic [THERM_W-1:0] wt_o
);
    dec_st_t st_d, st_q;
    logic [PROD_W-1:0]  prod;
    logic [LVL_W-1:0]   lvl;
    logic [THERM_W-1:0] therm;
    sect_t              sect;

    assign prod = PROD_W'(phase_i) * PROD_W'(NSECT);
    assign sect = prod[PROD_W-1:PHASE_W];
    assign lvl  = prod[PHASE_W-1 -: LVL_W];

    for (genvar i = 0; i < THERM_W; i++) begin : g_therm
        assign therm[i] = (LVL_W'(i) < lvl);
    end

    always_comb begin
        st_d.lo = sect;
        st_d.hi = (sect == sect_t'(NSECT - 1)) ? '0 : sect + sect_t'(1);
        st_d.wt = therm;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '{lo: '0, hi: sect_t'(1), wt: '0};
        else       st_q <= st_d;
    end

    assign lo_o = st_q.lo;
    assign hi_o = st_q.hi;
    assign wt_o = st_q.wt;
endmodule

// File: rtl/pmc_top.sv
module pmc_top
    import pmc_pkg::*;
#(
    parameter int FILT_N = 1
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               up_i,
    input  logic               dn_i,
    input  logic               ofs_we_i,
    input  logic [PHASE_W-1:0] ofs_val_i,
    output logic [SECT_W-1:0]  sel_lo_o,
    output logic [SECT_W-1:0]  sel_hi_o,
    output logic [THERM_W-1:0] weight_o
);
    logic   step_up, step_dn;
    phase_t cnt_w, ofs_w, phase_w;

    pmc_vote #(.FILT_N(FILT_N)) u_vote (
        .clk_i(clk_i), .rst_i(rst_i), .up_i(up_i), .dn_i(dn_i),
        .step_up_o(step_up), .step_dn_o(step_dn)
    );

    pmc_acc u_acc (
        .clk_i(clk_i), .rst_i(rst_i), .step_up_i(step_up), .step_dn_i(step_dn),
        .ofs_we_i(ofs_we_i), .ofs_val_i(ofs_val_i),
        .cnt_o(cnt_w), .ofs_o(ofs_w), .phase_o(phase_w)
    );

    pmc_dec u_dec (
        .clk_i(clk_i), .rst_i(rst_i), .phase_i(phase_w),
        .lo_o(sel_lo_o), .hi_o(sel_hi_o), .wt_o(weight_o)
    );
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk
    import pmc_pkg::*;
#(
    parameter int FILT_N = 1
) (
    input logic               clk,
    input logic               rst,
    input logic               up,
    input logic               dn,
    input logic               we,
    input logic [PHASE_W-1:0] wdata,
    input logic [PHASE_W-1:0] cnt,
    input logic [PHASE_W-1:0] ofs,
    input logic [SECT_W-1:0]  lo,
    input logic [THERM_W-1:0] wt
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (cnt == '0) && (ofs == '0));

    a_r2_up_step: assert property (@(posedge clk) disable iff (rst)
        (FILT_N == 1 && up && !dn) |=> cnt == $past(cnt) + PHASE_W'(1));

    a_r3_dn_step: assert property (@(posedge clk) disable iff (rst)
        (FILT_N == 1 && dn && !up) |=> cnt == $past(cnt) - PHASE_W'(1));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (up == dn) |=> $stable(cnt));

    a_r5_ofs_load: assert property (@(posedge clk) disable iff (rst)
        we |=> ofs == $past(wdata));

    a_r5_ofs_keep: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(ofs));

    a_r6_lo_range: assert property (@(posedge clk) disable iff (rst)
        lo < SECT_W'(NSECT));

    a_r8_therm: assert property (@(posedge clk) disable iff (rst)
        ((wt + THERM_W'(1)) & wt) == '0);
endmodule

bind pmc_top pmc_chk #(.FILT_N(FILT_N)) u_chk (
    .clk(clk_i), .rst(rst_i), .up(up_i), .dn(dn_i), .we(ofs_we_i),
    .wdata(ofs_val_i), .cnt(cnt_w), .ofs(ofs_w), .lo(sel_lo_o), .wt(weight_o)
);

// File: tb/sim_pmc_top.sv
module sim_pmc_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic       up0 = 0, dn0 = 0, we0 = 0;
    logic [7:0] wd0 = 0;
    logic [3:0] lo0, hi0;
    logic [6:0] wt0;
    logic       up1 = 0, dn1 = 0, we1 = 0;
    logic [7:0] wd1 = 0;
    logic [3:0] lo1, hi1;
    logic [6:0] wt1;

    pmc_top u0 (.clk_i(clk), .rst_i(rst), .up_i(up0), .dn_i(dn0),
        .ofs_we_i(we0), .ofs_val_i(wd0),
        .sel_lo_o(lo0), .sel_hi_o(hi0), .weight_o(wt0));

    pmc_top #(.FILT_N(3)) u1 (.clk_i(clk), .rst_i(rst), .up_i(up1), .dn_i(dn1),
        .ofs_we_i(we1), .ofs_val_i(wd1),
        .sel_lo_o(lo1), .sel_hi_o(hi1), .weight_o(wt1));

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 0;

    // entry: {up, dn, we, wdata[7:0], expected phase[7:0]}
    localparam int NV = 15;
    localparam logic [18:0] VEC [NV] = '{
        {3'b001,  8'd20,  8'd20},   // R5 offset load
        {3'b100,  8'd0,   8'd21},   // R2
        {3'b100,  8'd0,   8'd22},   // R2 R6 sector edge
        {3'b110,  8'd0,   8'd22},   // R4 both
        {3'b000,  8'd0,   8'd22},   // R4 idle
        {3'b010,  8'd0,   8'd21},   // R3
        {3'b010,  8'd0,   8'd20},   // R3
        {3'b010,  8'd0,   8'd19},   // R3 counter wraps to 255
        {3'b001,  8'd0,   8'd255},  // R5 R7 last sector
        {3'b100,  8'd0,   8'd0},    // R2 wrap to 0
        {3'b001,  8'd128, 8'd128},  // R5 R6
        {3'b100,  8'd0,   8'd129},  // R8
        {3'b100,  8'd0,   8'd130},  // R8
        {3'b100,  8'd0,   8'd131},  // R8 level step
        {3'b001,  8'd200, 8'd203}   // R5 counter kept
    };

    function automatic void expect_of(input int p, output logic [3:0] lo,
                                      output logic [3:0] hi, output logic [6:0] wt);
        int prod, sec, lvl;
        prod = p * 12;
        sec  = prod / 256;
        lvl  = (prod % 256) / 32;
        lo   = 4'(sec);
        hi   = 4'((sec + 1) % 12);
        wt   = 7'((1 << lvl) - 1);
    endfunction

    task automatic check(input string req, input logic [3:0] lo, input logic [3:0] hi,
                         input logic [6:0] wt, input int p);
        logic [3:0] elo, ehi;
        logic [6:0] ewt;
        expect_of(p, elo, ehi, ewt);
        total++;
        if (lo !== elo || hi !== ehi || wt !== ewt) begin
            bad++;
            $display("FAIL %s: got lo=%0d hi=%0d wt=%b, expected lo=%0d hi=%0d wt=%b (P=%0d)",
                     req, lo, hi, wt, elo, ehi, ewt, p);
        end
    endtask

    // one cycle of stimulus on u0, then one cycle for the decode register (R9)
    task automatic drive0(input logic u, input logic d, input logic w, input logic [7:0] v);
        up0 = u; dn0 = d; we0 = w; wd0 = v;
        @(negedge clk);
        up0 = 0; dn0 = 0; we0 = 0;
        @(negedge clk);
    endtask

    task automatic drive1(input logic u, input logic d, input logic w, input logic [7:0] v);
        up1 = u; dn1 = d; we1 = w; wd1 = v;
        @(negedge clk);
        up1 = 0; dn1 = 0; we1 = 0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++; bad++;
            $display("FAIL watchdog: got %0d cycles, expected fewer than 20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset u0", lo0, hi0, wt0, 0);
        check("R1 reset u1", lo1, hi1, wt1, 0);

        for (int i = 0; i < NV; i++) begin
            drive0(VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:8]);
            check($sformatf("R9 vector %0d (R2 R3 R4 R5 R6 R7 R8)", i), lo0, hi0, wt0,
                  int'(VEC[i][7:0]));
        end

        // R9: output lags the counter by one edge
        up0 = 1;
        @(negedge clk);
        up0 = 0;
        check("R9 not yet updated", lo0, hi0, wt0, 203);
        @(negedge clk);
        check("R9 updated", lo0, hi0, wt0, 204);

        // R10: three-vote filter on u1, parked at P=21 so one step reaches sector 1
        drive1(0, 0, 1, 8'd21);
        check("R10 park", lo1, hi1, wt1, 21);
        drive1(1, 0, 0, 8'd0);
        drive1(1, 0, 0, 8'd0);
        check("R10 two votes no step", lo1, hi1, wt1, 21);
        drive1(0, 1, 0, 8'd0);
        drive1(1, 0, 0, 8'd0);
        drive1(0, 0, 0, 8'd0);
        drive1(1, 0, 0, 8'd0);
        drive1(1, 1, 0, 8'd0);
        check("R10 restart after opposite vote", lo1, hi1, wt1, 21);
        drive1(1, 0, 0, 8'd0);
        check("R10 third vote steps", lo1, hi1, wt1, 22);
        drive1(0, 1, 0, 8'd0);
        drive1(0, 1, 0, 8'd0);
        drive1(0, 1, 0, 8'd0);
        check("R10 three down votes step", lo1, hi1, wt1, 21);

        // R1: reset mid-run clears counter and offset
        rst = 1;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset after run", lo0, hi0, wt0, 0);
        drive0(0, 1, 0, 8'd0);
        check("R3 wrap from 0 after reset", lo0, hi0, wt0, 255);

        finish_run();
    end
endmodule